// File: doc/BRIEF.md
# Dual-Law SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the module clock. A single configuration word holds two divider fields and a select bit. With the select bit set, the serial clock period is 2×(n+1) module clocks, n being an 8-bit value. With it clear, the period is 2^(n+1) module clocks, n being a 4-bit exponent. The fast linear law covers fine rate steps. The exponential law reaches very slow rates from a few bits.

The shift engine holds `xfer_active` high for the length of a transfer. While it is low, the serial clock rests at the idle polarity and the divider count stays cleared. When a transfer begins, the count restarts, so the first half-period has its full length. A write to the configuration word also restarts the count, and the new setting governs every half-period that follows. Every change of the serial clock comes with one single-cycle strobe. `lead_tick` marks a move away from the idle level and `trail_tick` marks the return to it, so the shift engine can launch and capture data without sampling the clock itself.

Top module: `spi_sck_divider`

## Requirements
- R1: After reset the configuration word is zero, `sck` equals `cpol`, and both tick strobes are low.
- R2: With bit 12 of the configuration word set (linear law), each half-period of `sck` lasts n+1 module clocks, where n is bits 7:0. Bits 11:8 have no effect in this law.
- R3: With the linear law and n = 0, `sck` changes on every module clock, giving half the module clock rate.
- R4: With bit 12 clear (exponential law), each half-period lasts 2^n module clocks, where n is bits 11:8. Bits 7:0 have no effect in this law.
- R5: While `xfer_active` is low, `sck` equals `cpol` and neither tick strobe pulses.
- R6: The first edge of `sck` after `xfer_active` rises comes a full half-period after the first clock edge at which `xfer_active` is seen high.
- R7: A configuration write clears the count without moving `sck`. The next change of `sck` comes one full half-period of the new setting after the write.
- R8: `lead_tick` is high for exactly the cycle in which `sck` first shows the level opposite to `cpol`. `trail_tick` is high for exactly the cycle in which `sck` returns to `cpol`.
- R9: The two strobes are never high together, and every change of `sck` during a transfer is accompanied by exactly one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 13 | Configuration word: [7:0] linear n, [11:8] exponent n, [12] law select (1 = linear) |
| cpol | input | 1 | Idle level of the serial clock |
| xfer_active | input | 1 | High for the duration of a transfer |
| sck | output | 1 | Serial clock |
| lead_tick | output | 1 | One-cycle strobe on each move of `sck` away from idle |
| trail_tick | output | 1 | One-cycle strobe on each return of `sck` to idle |

## Verification
The assertions assume that `cpol` does not change while a transfer is running. The edge-versus-strobe properties therefore only apply over cycles in which `cpol` is stable. The stimulus changes `cpol` only while `xfer_active` is low. Configuration writes land both between transfers and in the middle of one, including writes that set the unused field of the chosen law to a non-zero value. Exponents stay small enough that several full periods fit into each run segment.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
   localparam int DEF_LIN_W = 8;
   localparam int DEF_EXP_W = 4;

   typedef enum logic {
      LAW_POW2   = 1'b0,
      LAW_LINEAR = 1'b1
   } div_law_e;
endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
   import spi_div_pkg::*;
#(
   parameter int LIN_W  = DEF_LIN_W,
   parameter int EXP_W  = DEF_EXP_W,
   parameter int CFG_W  = LIN_W + EXP_W + 1,
   parameter int TERM_W = (LIN_W > (2**EXP_W - 1)) ? LIN_W : (2**EXP_W - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CFG_W-1:0]  wdata,
   output logic [TERM_W-1:0] term
);
   localparam int EXP_LSB = LIN_W;
   localparam int SEL_POS = LIN_W + EXP_W;

   logic [CFG_W-1:0]  cfg_q;
   logic [LIN_W-1:0]  lin_n;
   logic [EXP_W-1:0]  exp_n;
   div_law_e          law;
   logic [TERM_W-1:0] pow_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else if (wr) cfg_q <= wdata;
   end

   assign lin_n = cfg_q[LIN_W-1:0];
   assign exp_n = cfg_q[EXP_LSB +: EXP_W];
   assign law   = div_law_e'(cfg_q[SEL_POS]);

   // half-period minus one for the exponential law: 2^n - 1 as a thermometer mask
   for (genvar i = 0; i < TERM_W; i++) begin : g_mask
      if (i < 2**EXP_W - 1) begin : g_live
         assign pow_mask[i] = (EXP_W'(i) < exp_n);
      end else begin : g_dead
         assign pow_mask[i] = 1'b0;
      end
   end

   always_comb begin
      if (law == LAW_LINEAR) term = TERM_W'(lin_n);
      else                   term = pow_mask;
   end

   // R1: configuration word is cleared by reset, so the terminal starts at zero
   assert_term_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> term == '0);
endmodule

// File: rtl/spi_div_count.sv
module spi_div_count #(
   parameter int TERM_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              start,
   input  logic              reload,
   input  logic [TERM_W-1:0] term,
   output logic              phase,
   output logic              lead,
   output logic              trail
);
   logic [TERM_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
         lead  <= 1'b0;
         trail <= 1'b0;
      end else begin
         lead  <= 1'b0;
         trail <= 1'b0;
         if (!run) begin
            cnt   <= '0;
            phase <= 1'b0;
         end else if (start || reload) begin
            cnt <= '0;
            if (start) phase <= 1'b0;
         end else if (cnt == term) begin
            cnt   <= '0;
            phase <= ~phase;
            lead  <= ~phase;
            trail <= phase;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R2: the count never passes the terminal of the active setting
   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= term);

   // R7: a configuration write clears the count and leaves the phase alone
   assert_reload_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && reload && !start) |=> (cnt == '0) && $stable(phase));

   // R9: strobes are exclusive
   assert_tick_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead && trail));
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
   import spi_div_pkg::*;
#(
   parameter int LIN_W = DEF_LIN_W,
   parameter int EXP_W = DEF_EXP_W,
   localparam int CFG_W  = LIN_W + EXP_W + 1,
   localparam int TERM_W = (LIN_W > (2**EXP_W - 1)) ? LIN_W : (2**EXP_W - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             cpol,
   input  logic             xfer_active,
   output logic             sck,
   output logic             lead_tick,
   output logic             trail_tick
);
   if (LIN_W < 1 || LIN_W > 16) begin : g_bad_lin
      $error("spi_sck_divider: LIN_W must lie in 1..16");
   end
   if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
      $error("spi_sck_divider: EXP_W must lie in 1..5");
   end

   logic              active_q;
   logic              start;
   logic              phase;
   logic [TERM_W-1:0] term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= xfer_active;
   end

   assign start = xfer_active && !active_q;

   spi_div_cfg #(
      .LIN_W (LIN_W),
      .EXP_W (EXP_W),
      .CFG_W (CFG_W),
      .TERM_W(TERM_W)
   ) u_cfg (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (cfg_wr),
      .wdata(cfg_wdata),
      .term (term)
   );

   spi_div_count #(
      .TERM_W(TERM_W)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (xfer_active),
      .start (start),
      .reload(cfg_wr),
      .term  (term),
      .phase (phase),
      .lead  (lead_tick),
      .trail (trail_tick)
   );

   assign sck = cpol ^ phase;

   // R5: idle level held between transfers
   assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_active && !active_q) |-> (sck == cpol) && !lead_tick && !trail_tick);

   // R8: strobe direction matches the new sck level
   assert_lead_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lead_tick |-> sck != cpol);
   assert_trail_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trail_tick |-> sck == cpol);

   // R9: every edge inside a transfer carries a strobe
   assert_edge_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && $past(xfer_active) && $stable(cpol) && (sck != $past(sck)))
      |-> (lead_tick || trail_tick));
endmodule

// File: tb/spi_sck_divider_bench.sv
`timescale 1ns/1ps
module spi_sck_divider_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [12:0] cfg_wdata = '0;
   logic        cpol = 1'b0;
   logic        xfer_active = 1'b0;
   logic        sck, lead_tick, trail_tick;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   string cur_req = "R1";

   // behavioural reference state
   int  m_cfg = 0;
   int  m_elapsed = 0;
   bit  m_away = 0;
   bit  m_lead = 0, m_trail = 0;
   bit  m_act_d = 0;
   bit  model_on = 0;

   always #2 clk = ~clk;

   spi_sck_divider u_spi_sck_divider (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_wdata  (cfg_wdata),
      .cpol       (cpol),
      .xfer_active(xfer_active),
      .sck        (sck),
      .lead_tick  (lead_tick),
      .trail_tick (trail_tick)
   );

   function automatic int half_len(int cfg);
      if (cfg[12]) return (cfg & 255) + 1;
      return 1 << ((cfg >> 8) & 15);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 0; m_elapsed = 0; m_away = 0;
         m_lead = 0; m_trail = 0; m_act_d = 0;
      end else begin
         int h;
         bit st;
         h = half_len(m_cfg);
         st = xfer_active && !m_act_d;
         m_act_d = xfer_active;
         m_lead = 0; m_trail = 0;
         if (cfg_wr) m_cfg = int'(cfg_wdata);
         if (!xfer_active) begin
            m_elapsed = 0; m_away = 0;
         end else if (st || cfg_wr) begin
            m_elapsed = 0;
            if (st) m_away = 0;
         end else begin
            m_elapsed++;
            if (m_elapsed >= h) begin
               m_elapsed = 0;
               m_away = !m_away;
               if (m_away) m_lead = 1; else m_trail = 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (model_on) begin
         bit exp_sck;
         exp_sck = cpol ^ m_away;
         checks++;
         if (sck !== exp_sck || lead_tick !== m_lead || trail_tick !== m_trail) begin
            failures++;
            $display("FAIL %s: sck/lead/trail got %b%b%b expected %b%b%b at cycle %0d",
                     cur_req, sck, lead_tick, trail_tick, exp_sck, m_lead, m_trail, cycles);
         end
      end
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog: got running expected finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic write_cfg(logic [12:0] v);
      cfg_wr = 1'b1;
      cfg_wdata = v;
      step(1);
      cfg_wr = 1'b0;
   endtask

   task automatic expect_eq(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // cycles between two consecutive lead strobes
   task automatic measure_period(output int per);
      int guard;
      per = 0;
      guard = 0;
      while (lead_tick !== 1'b1 && guard < 100000) begin step(1); guard++; end
      step(1);
      per = 1;
      while (lead_tick !== 1'b1 && per < 100000) begin step(1); per++; end
   endtask

   // cycles from start until first sck change
   task automatic first_edge(output int dly);
      logic idle;
      idle = cpol;
      xfer_active = 1'b1;
      dly = 0;
      step(1);
      while (sck === idle && dly < 100000) begin step(1); dly++; end
   endtask

   initial begin
      int per;
      int dly;
      step(2);
      // R1: reset state
      expect_eq("R1 sck", int'(sck), 0);
      expect_eq("R1 ticks", int'(lead_tick) + int'(trail_tick), 0);
      rst_n = 1'b1;
      model_on = 1;
      step(3);

      // R1: reset config is exponent 0, half-period of 1 clock
      cur_req = "R1";
      xfer_active = 1'b1;
      step(12);
      xfer_active = 1'b0;
      step(3);

      // R2 + R6: linear n=3, exponent field garbage
      cur_req = "R2";
      write_cfg(13'h1000 | 13'h0A00 | 13'd3);
      cur_req = "R6";
      first_edge(dly);
      expect_eq("R6 first edge delay", dly, 4);
      cur_req = "R2";
      measure_period(per);
      expect_eq("R2 linear n=3 period", per, 8);
      step(10);
      expect_eq("R8 lead level", int'(sck != cpol || !lead_tick), 1);

      // R5: idle holds cpol, including cpol=1
      cur_req = "R5";
      xfer_active = 1'b0;
      step(2);
      cpol = 1'b1;
      step(8);
      expect_eq("R5 idle sck", int'(sck), 1);

      // R3: linear n=0 with cpol=1
      cur_req = "R3";
      write_cfg(13'h1000);
      xfer_active = 1'b1;
      step(2);
      measure_period(per);
      expect_eq("R3 linear n=0 period", per, 2);
      step(10);
      xfer_active = 1'b0;
      step(3);
      cpol = 1'b0;
      step(2);

      // R4: exponential law, linear field garbage
      cur_req = "R4";
      write_cfg(13'h0200 | 13'h5B);
      first_edge(dly);
      expect_eq("R4 first edge n=2", dly, 4);
      measure_period(per);
      expect_eq("R4 pow2 n=2 period", per, 8);
      xfer_active = 1'b0;
      step(2);
      write_cfg(13'h0500);
      xfer_active = 1'b1;
      step(2);
      measure_period(per);
      expect_eq("R4 pow2 n=5 period", per, 64);
      step(20);
      xfer_active = 1'b0;
      step(3);

      // R7: mid-transfer rewrite from linear n=5 to n=1
      cur_req = "R7";
      write_cfg(13'h1005);
      xfer_active = 1'b1;
      step(15);
      write_cfg(13'h1001);
      step(12);
      measure_period(per);
      expect_eq("R7 new period after rewrite", per, 4);
      // rewrite right after an edge: next edge two clocks after write
      write_cfg(13'h1001);
      step(9);
      write_cfg(13'h0000);
      step(10);

      // R8 / R9: per-cycle model compare over a long linear run
      cur_req = "R9";
      write_cfg(13'h1002);
      step(40);
      xfer_active = 1'b0;
      step(5);

      model_on = 0;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule